// File: doc/BRIEF.md
# Serially Addressed Switch-Enable Register

This block is a two-wire bus target that owns one 8-bit control word. Each bit of the word drives one enable output, so a bus master can switch any mix of eight external channels on or off: all, none, or any subset. The bus clock and data lines are brought into a faster system clock domain. They pass through a two-stage synchroniser and a per-line pulse filter. A state machine then detects bus conditions, matches the target address, takes in data and returns the word on reads.

The 7-bit target address is a 5-bit prefix, set by the parameter `ADDR_PREFIX`, followed by two strap inputs. This lets up to four targets of each prefix share one bus. A write may carry any number of data bytes after the address. Each byte replaces the whole word and reaches the outputs at once. A read sends back the current word, once for each byte the master acknowledges. The open-drain data line is modelled by `sda_oe`: a 1 means the block pulls the line low.

The state machine has eight states:
- ST_IDLE: waits for START.
- ST_ADDR: shifts in the address byte.
- ST_ADDR_ACK: drives the address acknowledge.
- ST_WR_DATA: shifts in a data byte.
- ST_WR_ACK: drives the data acknowledge.
- ST_RD_DATA: shifts out the word.
- ST_RD_ACK: samples the master's acknowledge.
- ST_SKIP: stays silent until the next START or STOP.

Its transitions are:
- START from any state goes to ST_ADDR. STOP from any state goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on a match, or to ST_SKIP on a mismatch.
- ST_ADDR_ACK goes to ST_RD_DATA or ST_WR_DATA, chosen by the direction bit.
- ST_WR_DATA goes to ST_WR_ACK, and ST_WR_ACK goes back to ST_WR_DATA.
- ST_RD_DATA goes to ST_RD_ACK. ST_RD_ACK goes to ST_RD_DATA when the master acknowledges, or to ST_SKIP when it does not.

Top module: `swreg_i2c_slave`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sw_en` is all zeros and `sda_oe` is 0.
- R2: The target address is `{ADDR_PREFIX, strap_a1, strap_a0}`: the prefix in the top five bits, `strap_a1` in bit 1 and `strap_a0` in bit 0. The first byte after START is that address followed by a direction bit (1 = read, 0 = write). On a match the block pulls SDA low for the whole ninth SCL pulse.
- R3: On an address mismatch the block never drives SDA and ignores all later bytes until the next START. `sw_en` keeps its value.
- R4: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. STOP ends any transfer, and a byte cut short by STOP has no effect on `sw_en`.
- R5: Data bits arrive most significant bit first. Bit k of a received byte drives `sw_en[k]`, so bit 7 controls switch 8 and bit 0 controls switch 1. A 1 turns a switch on.
- R6: In a write, every data byte is acknowledged. The byte replaces the whole word on the SCL falling edge that ends its eighth bit, and any number of bytes may follow in one transfer.
- R7: In a read, the block sends the current word MSB first. If the master acknowledges, the word is sent again. After a no-acknowledge the block releases SDA until START or STOP.
- R8: A pulse on SCL or SDA shorter than `FILTER_CYCLES` system clocks (50 ns at 100 MHz) is ignored.
- R9: The block changes `sda_oe` only while SCL is low.
- R10: A repeated START during a transfer discards the partly received byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| strap_a1 | input | 1 | Address strap, bit 1 of the target address |
| strap_a0 | input | 1 | Address strap, bit 0 of the target address |
| sda_oe | output | 1 | 1 pulls the data line low |
| sw_en | output | 8 | Switch enables, bit k drives switch k+1 |

## Verification
On every cycle, the assertions check four things:
- The filtered line levels change only after the synchronised input has shown the new level.
- The data-line drive changes only while the filtered clock is low.
- The control word changes only when the machine enters the write-acknowledge state.
- The skip and read-acknowledge states never drive the line, and the address-acknowledge state always does.

Only the bench's scenarios can show the end-to-end meaning at the pins:
- that the address compare uses the right prefix and strap order;
- that bits land in the right switch positions;
- that repeated reads return the same word;
- that filtered glitches leave a byte intact;
- that a repeated START or a STOP discards a partial byte.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BITCNT_W = $clog2(BYTE_W + 1);
    localparam int unsigned N_LINES  = 2;
    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_SKIP
    } swreg_state_e;
endpackage

// File: rtl/swreg_line_cond.sv
module swreg_line_cond #(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned FILTER_CYCLES = 5,
    parameter logic        IDLE_LEVEL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    assign sync_last = sync_q[SYNC_STAGES-1];

    generate
        if (FILTER_CYCLES <= 1) begin : g_nofilt
            logic clean_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clean_q <= IDLE_LEVEL;
                end else begin
                    clean_q <= sync_last;
                end
            end
            assign clean_o = clean_q;
        end else begin : g_filt
            localparam int unsigned CNT_W = $clog2(FILTER_CYCLES);
            localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILTER_CYCLES - 1);
            logic [CNT_W-1:0] cnt_q;
            logic             clean_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q   <= '0;
                    clean_q <= IDLE_LEVEL;
                end else if (sync_last != clean_q) begin
                    if (cnt_q == CNT_MAX) begin
                        cnt_q   <= '0;
                        clean_q <= sync_last;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    cnt_q <= '0;
                end
            end
            assign clean_o = clean_q;

            // R8
            filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clean_q != $past(clean_q)) |-> ($past(sync_last) == clean_q));
        end
    endgenerate
endmodule

// File: rtl/swreg_bus_evt.sv
module swreg_bus_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    assign scl_rise  =  scl_c & ~scl_q;
    assign scl_fall  = ~scl_c &  scl_q;
    assign start_det =  scl_c &  scl_q &  sda_q & ~sda_c;
    assign stop_det  =  scl_c &  scl_q & ~sda_q &  sda_c;
endmodule

// File: rtl/swreg_proto_fsm.sv
module swreg_proto_fsm
    import swreg_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              strap_a1,
    input  logic              strap_a0,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ctrl_o
);
    swreg_state_e         state_q, state_d;
    logic [BITCNT_W-1:0]  bitcnt_q, bitcnt_d;
    logic [BYTE_W-1:0]    shift_q, shift_d;
    logic [BYTE_W-1:0]    tx_q, tx_d;
    logic [BYTE_W-1:0]    ctrl_q, ctrl_d;
    logic                 oe_q, oe_d;
    logic                 more_q, more_d;
    logic                 byte_done;
    logic                 addr_hit;

    assign byte_done = (bitcnt_q == BITCNT_W'(BYTE_W));
    assign addr_hit  = (shift_q[BYTE_W-1:1] == {ADDR_PREFIX, strap_a1, strap_a0});

    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        shift_d  = shift_q;
        tx_d     = tx_q;
        ctrl_d   = ctrl_q;
        oe_d     = oe_q;
        more_d   = more_q;
        if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d  = ST_ADDR;
            bitcnt_d = '0;
            oe_d     = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: begin
                    oe_d = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise && !byte_done) begin
                        shift_d  = {shift_q[BYTE_W-2:0], sda_lvl};
                        bitcnt_d = bitcnt_q + 1'b1;
                    end else if (scl_fall && byte_done) begin
                        if (addr_hit) begin
                            state_d = ST_ADDR_ACK;
                            oe_d    = 1'b1;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt_d = '0;
                        if (shift_q[0]) begin
                            state_d = ST_RD_DATA;
                            tx_d    = ctrl_q;
                            oe_d    = ~ctrl_q[BYTE_W-1];
                        end else begin
                            state_d = ST_WR_DATA;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise && !byte_done) begin
                        shift_d  = {shift_q[BYTE_W-2:0], sda_lvl};
                        bitcnt_d = bitcnt_q + 1'b1;
                    end else if (scl_fall && byte_done) begin
                        state_d = ST_WR_ACK;
                        ctrl_d  = shift_q;
                        oe_d    = 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_d  = ST_WR_DATA;
                        bitcnt_d = '0;
                        oe_d     = 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise && !byte_done) begin
                        bitcnt_d = bitcnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            state_d = ST_RD_ACK;
                            oe_d    = 1'b0;
                        end else begin
                            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
                            oe_d = ~tx_q[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        more_d = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (more_q) begin
                            state_d  = ST_RD_DATA;
                            bitcnt_d = '0;
                            tx_d     = ctrl_q;
                            oe_d     = ~ctrl_q[BYTE_W-1];
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shift_q  <= '0;
            tx_q     <= '0;
            ctrl_q   <= '0;
            oe_q     <= 1'b0;
            more_q   <= 1'b0;
        end else begin
            bitcnt_q <= bitcnt_d;
            shift_q  <= shift_d;
            tx_q     <= tx_d;
            ctrl_q   <= ctrl_d;
            oe_q     <= oe_d;
            more_q   <= more_d;
        end
    end

    assign sda_oe = oe_q;
    assign ctrl_o = ctrl_q;

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !scl_lvl);

    // R6
    ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> (state_q == ST_WR_ACK));

    // R3
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !oe_q);

    // R2
    addr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> oe_q);

    // R7
    rd_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK) |-> !oe_q);
endmodule

// File: rtl/swreg_i2c_slave.sv
module swreg_i2c_slave
    import swreg_pkg::*;
#(
    parameter logic [4:0]  ADDR_PREFIX   = 5'b10011,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned FILTER_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_a1,
    input  logic              strap_a0,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] sw_en
);
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    generate
        for (genvar li = 0; li < N_LINES; li++) begin : g_line
            swreg_line_cond #(
                .SYNC_STAGES  (SYNC_STAGES),
                .FILTER_CYCLES(FILTER_CYCLES),
                .IDLE_LEVEL   (1'b1)
            ) u_cond (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw_lines[li]),
                .clean_o(clean_lines[li])
            );
        end
    endgenerate

    swreg_bus_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_c    (clean_lines[LINE_SCL]),
        .sda_c    (clean_lines[LINE_SDA]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    swreg_proto_fsm #(
        .ADDR_PREFIX(ADDR_PREFIX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (clean_lines[LINE_SCL]),
        .sda_lvl  (clean_lines[LINE_SDA]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .strap_a1 (strap_a1),
        .strap_a0 (strap_a0),
        .sda_oe   (sda_oe),
        .ctrl_o   (sw_en)
    );
endmodule

// File: tb/sim_swreg_i2c_slave.sv
module sim_swreg_i2c_slave;
    localparam int Q = 20;
    localparam logic [4:0] PREFIX = 5'b10011;
    localparam logic [4:0] OTHER  = 5'b10001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic a1 = 1'b0;
    logic a0 = 1'b0;
    logic sda_oe;
    logic [7:0] sw_en;
    logic sda_line;
    logic [7:0] model = 8'h00;
    int n_checks = 0;
    int n_err = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    swreg_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_a1(a1), .strap_a0(a0), .sda_oe(sda_oe), .sw_en(sw_en)
    );

    function automatic logic [7:0] addr_byte(input logic [4:0] pre, input logic b1,
                                             input logic b0, input logic rd);
        return {pre, b1, b0, rd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, input logic glitch);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i];
            if (glitch) begin
                w(4); scl_m = 1'b1; w(3); scl_m = 1'b0; w(Q - 7);
            end else begin
                w(Q);
            end
            scl_m = 1'b1; w(2 * Q);
            scl_m = 1'b0; w(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
        send_bits(b, 8, glitch);
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        ack = sda_line; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q);
            scl_m = 1'b1; w(Q);
            b[i] = sda_line;
            w(Q - 1);
            check("R9 data held while SCL high", sda_line, b[i]);
            w(1);
            scl_m = 1'b0; w(Q);
        end
        sda_m = master_ack ? 1'b0 : 1'b1; w(Q);
        scl_m = 1'b1; w(2 * Q);
        scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rd;
        void'($urandom(32'h5eed_0042));
        w(10);
        check("R1 reset sw_en", sw_en, 8'h00);
        check("R1 reset sda_oe", sda_oe, 1'b0);
        rst_n = 1'b1;
        a1 = 1'b1; a0 = 1'b0;
        w(20);
        check("R1 after release sw_en", sw_en, 8'h00);

        // multi-byte write
        bus_start();
        send_byte(addr_byte(PREFIX, a1, a0, 1'b0), 1'b0, ack);
        check("R2 address ack", ack, 1'b0);
        send_byte(8'hA5, 1'b0, ack); model = 8'hA5;
        check("R6 data ack", ack, 1'b0);
        check("R6 first byte applied", sw_en, model);
        send_byte(8'h80, 1'b0, ack); model = 8'h80;
        check("R5 bit7 drives switch 8", sw_en, model);
        send_byte(8'h01, 1'b0, ack); model = 8'h01;
        check("R5 bit0 drives switch 1", sw_en, model);
        check("R6 third byte ack", ack, 1'b0);
        bus_stop();
        check("R4 stop keeps word", sw_en, model);

        // read with repeat
        bus_start();
        send_byte(addr_byte(PREFIX, a1, a0, 1'b1), 1'b0, ack);
        check("R7 read address ack", ack, 1'b0);
        read_byte(1'b1, rd);
        check("R7 first read", rd, model);
        read_byte(1'b0, rd);
        check("R7 repeated read", rd, model);
        w(Q);
        check("R7 release after nack", sda_oe, 1'b0);
        bus_stop();

        // mismatch: wrong strap bit, then other prefix
        bus_start();
        send_byte(addr_byte(PREFIX, a1, ~a0, 1'b0), 1'b0, ack);
        check("R3 no ack on strap mismatch", ack, 1'b1);
        send_byte(8'hFF, 1'b0, ack);
        check("R3 data ignored, no ack", ack, 1'b1);
        bus_stop();
        check("R3 word unchanged", sw_en, model);
        bus_start();
        send_byte(addr_byte(OTHER, a1, a0, 1'b0), 1'b0, ack);
        check("R2 other prefix not acked", ack, 1'b1);
        bus_stop();

        // glitches on SCL during low phases
        bus_start();
        send_byte(addr_byte(PREFIX, a1, a0, 1'b0), 1'b1, ack);
        check("R8 address ack with glitches", ack, 1'b0);
        send_byte(8'h3C, 1'b1, ack); model = 8'h3C;
        check("R8 byte intact with glitches", sw_en, model);
        bus_stop();

        // repeated START mid byte
        bus_start();
        send_byte(addr_byte(PREFIX, a1, a0, 1'b0), 1'b0, ack);
        send_bits(8'hF0, 4, 1'b0);
        bus_start();
        send_byte(addr_byte(PREFIX, a1, a0, 1'b1), 1'b0, ack);
        check("R10 new address phase acked", ack, 1'b0);
        read_byte(1'b0, rd);
        check("R10 partial byte discarded", rd, model);
        bus_stop();

        // STOP mid byte
        bus_start();
        send_byte(addr_byte(PREFIX, a1, a0, 1'b0), 1'b0, ack);
        send_bits(8'h00, 3, 1'b0);
        bus_stop();
        check("R4 partial byte before stop discarded", sw_en, model);

        // constrained random
        for (int it = 0; it < 14; it++) begin
            logic good;
            logic [7:0] dat;
            logic [7:0] ab;
            a1 = 1'($urandom); a0 = 1'($urandom);
            good = ($urandom % 4) != 0;
            dat = 8'($urandom);
            ab = good ? addr_byte(PREFIX, a1, a0, 1'b0)
                      : addr_byte(($urandom % 2) ? OTHER : PREFIX, ~a1, a0, 1'b0);
            w(Q);
            bus_start();
            send_byte(ab, 1'b0, ack);
            check(good ? "R2 random ack" : "R3 random nack", ack, good ? 1'b0 : 1'b1);
            send_byte(dat, 1'b0, ack);
            if (good) model = dat;
            check("R6 random word", sw_en, model);
            bus_stop();
            bus_start();
            send_byte(addr_byte(PREFIX, a1, a0, 1'b1), 1'b0, ack);
            read_byte(1'b0, rd);
            check("R7 random readback", rd, model);
            bus_stop();
        end

        // reset mid operation
        rst_n = 1'b0; w(3);
        check("R1 reset clears word", sw_en, 8'h00);
        rst_n = 1'b1; w(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule